// File: doc/BRIEF.md
# Cross-Domain Call Unit

This block sits beside the instruction decoder of a small microcontroller core that has a single address space and wants hardware-enforced protection domains. Software sets up a jump table of exported entry points. Each domain owns one fixed, power-of-two sized run of slots in that table. When the decoder reports a call whose target lands inside the table, the unit treats it as a domain crossing. It derives the callee's domain number from the slot offset and holds the core stalled while it writes a five-byte frame to a safe stack kept in protected RAM. It then switches the active domain and moves the stack bound to the current run-time stack pointer. From that point the callee cannot write into its caller's frames.

The safe stack grows upward from a configured base, towards the run-time stack, which grows downward. A return is handled as a domain exit only when the safe stack holds at least one frame and the run-time stack pointer sits exactly at the current stack bound. On such a return the unit reads the frame back with the core stalled and restores the caller's domain and bound. It then presents the saved return address as a one-cycle redirect, which overrides whatever the run-time stack held. A call that would leave the safe stack too close to the run-time stack is refused and raises a one-cycle fault.

Top module: `cdc_unit`

## Requirements
- R1: After reset the active domain is 0, the stack bound is all ones, the safe stack pointer equals `cfg_ss_base`, and stall, RAM write and RAM read are all low.
- R2: A call counts as cross-domain only when `cfg_tbl_base <= call_target < cfg_tbl_bound`. Any other call target causes no stall, no RAM access and no change of state.
- R3: The callee domain is `(call_target - cfg_tbl_base) >> SLOT_SHIFT`, keeping the low DOM_W bits.
- R4: An accepted call writes five bytes, one per cycle, in the five cycles after the strobe cycle, at safe stack pointer +0 to +4. In that order they are: return address bits 7:0, return address bits 15:8, caller domain zero-extended to 8 bits, old stack bound bits 7:0, old stack bound bits 15:8. The return address is `pc + CALL_WORDS`.
- R5: For an accepted call, `stall` is high in the strobe cycle and in all five write cycles, which makes six cycles in total.
- R6: In the cycle after the last frame write, the active domain equals the callee, the stack bound equals `sp` as sampled in the strobe cycle, and the safe stack pointer has grown by 5.
- R7: A return strobe is a domain exit only when the safe stack pointer is above `cfg_ss_base` and `sp` equals the current stack bound. Otherwise it causes no stall, no RAM access and no change of state.
- R8: A domain exit reads, one per cycle, addresses safe stack pointer -1 down to -5 in the five cycles after the strobe. Read data arrives one cycle after its address. `stall` is high in the strobe cycle and in the six cycles after it.
- R9: In the cycle after the exit sequence ends, the domain and stack bound hold the popped values, the safe stack pointer has shrunk by 5, and `ret_redirect` is high for exactly one cycle with `ret_target` equal to the saved return address.
- R10: If safe stack pointer + 5 >= `sp` when a table call is strobed, nothing is written, no stall is raised, no state changes, and `ovf_fault` is high for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tbl_base | input | PA_W | First program address of the jump table |
| cfg_tbl_bound | input | PA_W | First program address past the jump table |
| cfg_ss_base | input | DA_W | Base data address of the safe stack |
| call_strobe | input | 1 | Decoder reports a call instruction |
| call_target | input | PA_W | Target address of that call |
| pc | input | PA_W | Address of the call instruction |
| ret_strobe | input | 1 | Decoder reports a return instruction |
| sp | input | DA_W | Current run-time stack pointer |
| ram_rdata | input | 8 | RAM read data, one cycle after the address |
| stall | output | 1 | Hold the core |
| ram_wr_en | output | 1 | RAM write enable |
| ram_rd_en | output | 1 | RAM read enable |
| ram_addr | output | DA_W | RAM address for read or write |
| ram_wdata | output | 8 | RAM write data |
| cur_dom | output | DOM_W | Active protection domain |
| stack_bound | output | DA_W | Lowest-permitted-write stack bound for the active domain |
| ss_ptr | output | DA_W | Safe stack pointer (next free byte) |
| ret_redirect | output | 1 | One-cycle pulse: take `ret_target` as the return address |
| ret_target | output | PA_W | Restored return address |
| ovf_fault | output | 1 | One-cycle safe stack overflow fault |

## Verification
The first pattern is a set of call targets just below the table base, exactly at the base, at the last slot and exactly at the bound. Together they separate a correct half-open range compare from one that is off by one at either end, and they also exercise the slot-to-domain shift. Two nested calls followed by two returns show that frames come back last-in first-out, with the inner domain and bound restored before the outer ones. A byte-order or address-direction error would show up here as a wrong redirect address. Returns issued with a stack pointer that differs from the bound, and with an empty safe stack, show that plain returns pass untouched. Stack pointers set one byte on either side of the overflow limit separate a `>=` compare from a `>` compare.

// File: rtl/cdc_pkg.sv
package cdc_pkg;

  // Bytes in one saved context record on the safe stack.
  localparam int FRAME_BYTES = 5;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_SAVE,
    SEQ_LOAD
  } seq_state_e;

  // Slot offset inside the jump table, scaled down to a domain number.
  function automatic logic [31:0] slot_to_domain(input logic [31:0] target,
                                                 input logic [31:0] base,
                                                 input int unsigned shift);
    return (target - base) >> shift;
  endfunction

  // True when a new record would touch or cross the run-time stack.
  function automatic logic record_collides(input logic [31:0] top,
                                           input logic [31:0] rt_sp);
    return (top + 32'(FRAME_BYTES)) >= rt_sp;
  endfunction

  // Byte k of a saved record, lowest address first.
  function automatic logic [7:0] record_byte(input logic [2:0]  k,
                                             input logic [15:0] ret,
                                             input logic [7:0]  dom,
                                             input logic [15:0] bnd);
    case (k)
      3'd0:    return ret[7:0];
      3'd1:    return ret[15:8];
      3'd2:    return dom;
      3'd3:    return bnd[7:0];
      default: return bnd[15:8];
    endcase
  endfunction

endpackage

// File: rtl/cdc_detect.sv
module cdc_detect #(
  parameter int PA_W       = 16,
  parameter int DOM_W      = 3,
  parameter int SLOT_SHIFT = 4
) (
  input  logic              call_strobe,
  input  logic [PA_W-1:0]   call_target,
  input  logic [PA_W-1:0]   tbl_base,
  input  logic [PA_W-1:0]   tbl_bound,
  output logic              table_hit,
  output logic [DOM_W-1:0]  callee_dom
);
  logic above_base;
  logic below_bound;

  assign above_base  = (call_target >= tbl_base);
  assign below_bound = (call_target < tbl_bound);
  assign table_hit   = call_strobe && above_base && below_bound;

  assign callee_dom = DOM_W'(cdc_pkg::slot_to_domain(32'(call_target),
                                                     32'(tbl_base),
                                                     SLOT_SHIFT));
endmodule

// File: rtl/cdc_ctx.sv
module cdc_ctx #(
  parameter int DA_W  = 16,
  parameter int DOM_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DA_W-1:0]   cfg_ss_base,
  input  logic              commit_call,
  input  logic              commit_ret,
  input  logic [DOM_W-1:0]  next_dom,
  input  logic [DA_W-1:0]   next_bound,
  output logic [DOM_W-1:0]  cur_dom,
  output logic [DA_W-1:0]   stack_bound,
  output logic [DA_W-1:0]   ss_depth,
  output logic [DA_W-1:0]   ss_ptr
);
  localparam logic [DA_W-1:0] REC_SZ = DA_W'(cdc_pkg::FRAME_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_dom     <= '0;
      stack_bound <= '1;
      ss_depth    <= '0;
    end else if (commit_call) begin
      cur_dom     <= next_dom;
      stack_bound <= next_bound;
      ss_depth    <= ss_depth + REC_SZ;
    end else if (commit_ret) begin
      cur_dom     <= next_dom;
      stack_bound <= next_bound;
      ss_depth    <= ss_depth - REC_SZ;
    end
  end

  assign ss_ptr = cfg_ss_base + ss_depth;

  // R9
  depth_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ret |-> (ss_depth >= REC_SZ));

  // R6
  dom_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_dom) |-> $past(commit_call || commit_ret));

  // R6
  commit_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_call && commit_ret));
endmodule

// File: rtl/cdc_seq.sv
module cdc_seq #(
  parameter int PA_W       = 16,
  parameter int DA_W       = 16,
  parameter int DOM_W      = 3,
  parameter int CALL_WORDS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              table_hit,
  input  logic [DOM_W-1:0]  callee_dom,
  input  logic              ret_strobe,
  input  logic [PA_W-1:0]   pc,
  input  logic [DA_W-1:0]   sp,
  input  logic [DOM_W-1:0]  cur_dom,
  input  logic [DA_W-1:0]   stack_bound,
  input  logic [DA_W-1:0]   ss_depth,
  input  logic [DA_W-1:0]   ss_ptr,
  input  logic [7:0]        ram_rdata,
  output logic              stall,
  output logic              ram_wr_en,
  output logic              ram_rd_en,
  output logic [DA_W-1:0]   ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              commit_call,
  output logic              commit_ret,
  output logic [DOM_W-1:0]  next_dom,
  output logic [DA_W-1:0]   next_bound,
  output logic              ret_redirect,
  output logic [PA_W-1:0]   ret_target,
  output logic              ovf_fault
);
  import cdc_pkg::*;

  localparam logic [2:0] SAVE_LAST = 3'(FRAME_BYTES - 1);
  localparam logic [2:0] LOAD_LAST = 3'(FRAME_BYTES);

  seq_state_e  state;
  logic [2:0]  step;

  // Record being saved or restored.
  logic [15:0]      rec_ret;
  logic [7:0]       rec_dom;
  logic [15:0]      rec_bnd;
  // Context to enter once the record is saved.
  logic [DOM_W-1:0] enter_dom;
  logic [DA_W-1:0]  enter_bnd;

  // Named events for the checks.
  logic idle;
  logic would_collide;
  logic call_go;
  logic call_refused;
  logic ret_go;
  logic save_last;
  logic load_last;

  assign idle          = (state == SEQ_IDLE);
  assign would_collide = record_collides(32'(ss_ptr), 32'(sp));
  assign call_go       = idle && table_hit && !would_collide;
  assign call_refused  = idle && table_hit && would_collide;
  assign ret_go        = idle && ret_strobe && !table_hit &&
                         (ss_depth != '0) && (sp == stack_bound);
  assign save_last     = (state == SEQ_SAVE) && (step == SAVE_LAST);
  assign load_last     = (state == SEQ_LOAD) && (step == LOAD_LAST);

  assign stall = call_go || ret_go || !idle;

  // RAM port.
  always_comb begin
    ram_wr_en = 1'b0;
    ram_rd_en = 1'b0;
    ram_addr  = '0;
    ram_wdata = '0;
    if (state == SEQ_SAVE) begin
      ram_wr_en = 1'b1;
      ram_addr  = ss_ptr + DA_W'(step);
      ram_wdata = record_byte(step, rec_ret, rec_dom, rec_bnd);
    end else if ((state == SEQ_LOAD) && (step < LOAD_LAST)) begin
      ram_rd_en = 1'b1;
      ram_addr  = ss_ptr - DA_W'(step) - DA_W'(1);
    end
  end

  // Context update towards the register block.
  assign commit_call = save_last;
  assign commit_ret  = load_last;
  assign next_dom    = (state == SEQ_SAVE) ? enter_dom : DOM_W'(rec_dom);
  assign next_bound  = (state == SEQ_SAVE) ? enter_bnd : DA_W'(rec_bnd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= SEQ_IDLE;
      step         <= '0;
      rec_ret      <= '0;
      rec_dom      <= '0;
      rec_bnd      <= '0;
      enter_dom    <= '0;
      enter_bnd    <= '0;
      ret_redirect <= 1'b0;
      ret_target   <= '0;
      ovf_fault    <= 1'b0;
    end else begin
      ret_redirect <= 1'b0;
      ovf_fault    <= call_refused;
      case (state)
        SEQ_IDLE: begin
          step <= '0;
          if (call_go) begin
            state     <= SEQ_SAVE;
            rec_ret   <= 16'(pc + PA_W'(CALL_WORDS));
            rec_dom   <= 8'(cur_dom);
            rec_bnd   <= 16'(stack_bound);
            enter_dom <= callee_dom;
            enter_bnd <= sp;
          end else if (ret_go) begin
            state <= SEQ_LOAD;
          end
        end
        SEQ_SAVE: begin
          if (save_last) begin
            state <= SEQ_IDLE;
            step  <= '0;
          end else begin
            step <= step + 3'd1;
          end
        end
        SEQ_LOAD: begin
          // Data for the address issued in step k-1 is present in step k.
          case (step)
            3'd1: rec_bnd[15:8] <= ram_rdata;
            3'd2: rec_bnd[7:0]  <= ram_rdata;
            3'd3: rec_dom       <= ram_rdata;
            3'd4: rec_ret[15:8] <= ram_rdata;
            default: ;
          endcase
          if (load_last) begin
            state        <= SEQ_IDLE;
            step         <= '0;
            ret_redirect <= 1'b1;
            ret_target   <= PA_W'({rec_ret[15:8], ram_rdata});
          end else begin
            step <= step + 3'd1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R4
  save_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr_en && $past(ram_wr_en)) |-> (ram_addr == $past(ram_addr) + DA_W'(1)));

  // R8
  load_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd_en && $past(ram_rd_en)) |-> (ram_addr == $past(ram_addr) - DA_W'(1)));

  // R5
  write_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr_en || ram_rd_en) |-> stall);

  // R10
  refused_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_refused |=> (!ram_wr_en && ovf_fault));

  // R9
  redirect_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_redirect |-> $past(commit_ret));

  // R4
  port_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_wr_en && ram_rd_en));
endmodule

// File: rtl/cdc_unit.sv
module cdc_unit #(
  parameter int PA_W       = 16,
  parameter int DA_W       = 16,
  parameter int DOM_W      = 3,
  parameter int SLOT_SHIFT = 4,
  parameter int CALL_WORDS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   cfg_tbl_base,
  input  logic [PA_W-1:0]   cfg_tbl_bound,
  input  logic [DA_W-1:0]   cfg_ss_base,
  input  logic              call_strobe,
  input  logic [PA_W-1:0]   call_target,
  input  logic [PA_W-1:0]   pc,
  input  logic              ret_strobe,
  input  logic [DA_W-1:0]   sp,
  input  logic [7:0]        ram_rdata,
  output logic              stall,
  output logic              ram_wr_en,
  output logic              ram_rd_en,
  output logic [DA_W-1:0]   ram_addr,
  output logic [7:0]        ram_wdata,
  output logic [DOM_W-1:0]  cur_dom,
  output logic [DA_W-1:0]   stack_bound,
  output logic [DA_W-1:0]   ss_ptr,
  output logic              ret_redirect,
  output logic [PA_W-1:0]   ret_target,
  output logic              ovf_fault
);
  logic              table_hit;
  logic [DOM_W-1:0]  callee_dom;
  logic              commit_call;
  logic              commit_ret;
  logic [DOM_W-1:0]  next_dom;
  logic [DA_W-1:0]   next_bound;
  logic [DA_W-1:0]   ss_depth;

  cdc_detect #(
    .PA_W       (PA_W),
    .DOM_W      (DOM_W),
    .SLOT_SHIFT (SLOT_SHIFT)
  ) u_detect (
    .call_strobe (call_strobe),
    .call_target (call_target),
    .tbl_base    (cfg_tbl_base),
    .tbl_bound   (cfg_tbl_bound),
    .table_hit   (table_hit),
    .callee_dom  (callee_dom)
  );

  cdc_seq #(
    .PA_W       (PA_W),
    .DA_W       (DA_W),
    .DOM_W      (DOM_W),
    .CALL_WORDS (CALL_WORDS)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .table_hit    (table_hit),
    .callee_dom   (callee_dom),
    .ret_strobe   (ret_strobe),
    .pc           (pc),
    .sp           (sp),
    .cur_dom      (cur_dom),
    .stack_bound  (stack_bound),
    .ss_depth     (ss_depth),
    .ss_ptr       (ss_ptr),
    .ram_rdata    (ram_rdata),
    .stall        (stall),
    .ram_wr_en    (ram_wr_en),
    .ram_rd_en    (ram_rd_en),
    .ram_addr     (ram_addr),
    .ram_wdata    (ram_wdata),
    .commit_call  (commit_call),
    .commit_ret   (commit_ret),
    .next_dom     (next_dom),
    .next_bound   (next_bound),
    .ret_redirect (ret_redirect),
    .ret_target   (ret_target),
    .ovf_fault    (ovf_fault)
  );

  cdc_ctx #(
    .DA_W  (DA_W),
    .DOM_W (DOM_W)
  ) u_ctx (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_ss_base (cfg_ss_base),
    .commit_call (commit_call),
    .commit_ret  (commit_ret),
    .next_dom    (next_dom),
    .next_bound  (next_bound),
    .cur_dom     (cur_dom),
    .stack_bound (stack_bound),
    .ss_depth    (ss_depth),
    .ss_ptr      (ss_ptr)
  );
endmodule

// File: tb/cdc_unit_test.sv
`timescale 1ns/1ps
module cdc_unit_test;
  localparam int TB_BASE  = 'h0200;
  localparam int TB_BOUND = 'h0280;
  localparam int SS_BASE  = 'h0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_tbl_base  = 16'(TB_BASE);
  logic [15:0] cfg_tbl_bound = 16'(TB_BOUND);
  logic [15:0] cfg_ss_base   = 16'(SS_BASE);
  logic        call_strobe = 1'b0;
  logic [15:0] call_target = '0;
  logic [15:0] pc = '0;
  logic        ret_strobe = 1'b0;
  logic [15:0] sp = 16'h0FF0;
  logic [7:0]  ram_rdata = '0;
  logic        stall, ram_wr_en, ram_rd_en, ret_redirect, ovf_fault;
  logic [15:0] ram_addr, stack_bound, ss_ptr, ret_target;
  logic [7:0]  ram_wdata;
  logic [2:0]  cur_dom;

  always #5 clk = ~clk;

  cdc_unit uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_tbl_base(cfg_tbl_base), .cfg_tbl_bound(cfg_tbl_bound),
    .cfg_ss_base(cfg_ss_base),
    .call_strobe(call_strobe), .call_target(call_target), .pc(pc),
    .ret_strobe(ret_strobe), .sp(sp), .ram_rdata(ram_rdata),
    .stall(stall), .ram_wr_en(ram_wr_en), .ram_rd_en(ram_rd_en),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .cur_dom(cur_dom), .stack_bound(stack_bound), .ss_ptr(ss_ptr),
    .ret_redirect(ret_redirect), .ret_target(ret_target),
    .ovf_fault(ovf_fault)
  );

  // Bench-side RAM, one cycle read latency.
  logic [7:0] mem [0:4095];
  initial for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
  always @(posedge clk) begin
    if (ram_wr_en) mem[ram_addr[11:0]] <= ram_wdata;
    if (ram_rd_en) ram_rdata <= mem[ram_addr[11:0]];
  end

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference model state.
  int m_mode = 0;      // 0 idle, 1 saving, 2 loading
  int m_cnt  = 0;
  int m_dom  = 0;
  int m_bnd  = 'hFFFF;
  int m_off  = 0;
  int p_dom, p_bnd;
  int fr_ret[$], fr_dom[$], fr_bnd[$];
  int wq_a[$], wq_d[$], rq_a[$];
  bit e_redir = 0;
  int e_tgt   = 0;
  bit e_fault = 0;

  task automatic cycle();
    bit hit, ovf, go_c, go_r, refused, e_stall;
    #1;
    hit     = call_strobe && (int'(call_target) >= TB_BASE) && (int'(call_target) < TB_BOUND);
    ovf     = (SS_BASE + m_off + 5) >= int'(sp);
    go_c    = (m_mode == 0) && hit && !ovf;
    refused = (m_mode == 0) && hit && ovf;
    go_r    = (m_mode == 0) && ret_strobe && !hit && (m_off > 0) && (int'(sp) == m_bnd);
    e_stall = go_c || go_r || (m_mode != 0);

    chk(m_mode == 2 ? "R8" : "R5", "stall", 32'(stall), 32'(e_stall));
    chk("R4", "wr_en", 32'(ram_wr_en), 32'(m_mode == 1));
    chk("R8", "rd_en", 32'(ram_rd_en), 32'(m_mode == 2 && m_cnt < 5));
    if (m_mode == 1) begin
      chk("R4", "wr addr", 32'(ram_addr), 32'(wq_a[0]));
      chk("R4", "wr data", 32'(ram_wdata), 32'(wq_d[0]));
    end
    if (m_mode == 2 && m_cnt < 5) chk("R8", "rd addr", 32'(ram_addr), 32'(rq_a[0]));
    chk("R6", "cur_dom", 32'(cur_dom), 32'(m_dom));
    chk("R6", "stack_bound", 32'(stack_bound), 32'(m_bnd));
    chk("R6", "ss_ptr", 32'(ss_ptr), 32'(SS_BASE + m_off));
    chk("R9", "ret_redirect", 32'(ret_redirect), 32'(e_redir));
    if (e_redir) chk("R9", "ret_target", 32'(ret_target), 32'(e_tgt));
    chk("R10", "ovf_fault", 32'(ovf_fault), 32'(e_fault));

    // Advance the model by one clock.
    e_redir = 0;
    e_fault = refused;
    if (m_mode == 1) begin
      void'(wq_a.pop_front()); void'(wq_d.pop_front());
      m_cnt++;
      if (m_cnt == 5) begin
        m_mode = 0; m_dom = p_dom; m_bnd = p_bnd; m_off += 5;
      end
    end else if (m_mode == 2) begin
      if (m_cnt < 5) void'(rq_a.pop_front());
      m_cnt++;
      if (m_cnt == 6) begin
        m_mode = 0;
        m_dom = fr_dom.pop_back();
        m_bnd = fr_bnd.pop_back();
        e_tgt = fr_ret.pop_back();
        e_redir = 1;
        m_off -= 5;
      end
    end
    if (go_c) begin
      int ret, top;
      ret = (int'(pc) + 2) & 'hFFFF;
      top = SS_BASE + m_off;
      wq_a.push_back(top);     wq_d.push_back(ret % 256);
      wq_a.push_back(top + 1); wq_d.push_back(ret / 256);
      wq_a.push_back(top + 2); wq_d.push_back(m_dom);
      wq_a.push_back(top + 3); wq_d.push_back(m_bnd % 256);
      wq_a.push_back(top + 4); wq_d.push_back(m_bnd / 256);
      fr_ret.push_back(ret); fr_dom.push_back(m_dom); fr_bnd.push_back(m_bnd);
      p_dom = ((int'(call_target) - TB_BASE) / 16) % 8;
      p_bnd = int'(sp);
      m_mode = 1; m_cnt = 0;
    end else if (go_r) begin
      for (int i = 1; i <= 5; i++) rq_a.push_back(SS_BASE + m_off - i);
      m_mode = 2; m_cnt = 0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic do_call(input int tgt, input int pcv, input int spv);
    call_target = 16'(tgt); pc = 16'(pcv); sp = 16'(spv); call_strobe = 1'b1;
    cycle();
    call_strobe = 1'b0;
    idle(8);
  endtask

  task automatic do_ret(input int spv);
    sp = 16'(spv); ret_strobe = 1'b1;
    cycle();
    ret_strobe = 1'b0;
    idle(9);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "cur_dom", 32'(cur_dom), 32'h0);
    chk("R1", "stack_bound", 32'(stack_bound), 32'hFFFF);
    chk("R1", "ss_ptr", 32'(ss_ptr), 32'(SS_BASE));
    chk("R1", "stall", 32'(stall), 32'h0);
    chk("R1", "wr/rd", 32'({ram_wr_en, ram_rd_en}), 32'h0);
    @(negedge clk);
    idle(2);

    // R2: just below the table and exactly at its bound are plain calls.
    do_call('h01FF, 'h0300, 'h0F00);
    do_call('h0280, 'h0300, 'h0F00);
    chk("R2", "ss_ptr after non-table calls", 32'(ss_ptr), 32'(SS_BASE));

    // Outer call into slot 3.
    do_call('h0235, 'h0400, 'h0F00);
    chk("R3", "callee of 0x235", 32'(cur_dom), 32'd3);
    chk("R6", "bound after outer call", 32'(stack_bound), 32'h0F00);

    // R7: return with sp away from the bound is ignored.
    do_ret('h0EF0);
    chk("R7", "dom after ignored return", 32'(cur_dom), 32'd3);

    // Nested call into the last slot.
    do_call('h027F, 'h1234, 'h0E80);
    chk("R3", "callee of 0x27F", 32'(cur_dom), 32'd7);
    do_ret('h0E80);
    chk("R9", "dom after inner return", 32'(cur_dom), 32'd3);
    do_ret('h0F00);
    chk("R9", "bound after outer return", 32'(stack_bound), 32'hFFFF);

    // R7: empty safe stack, sp at bound: ignored.
    do_ret('hFFFF);
    chk("R7", "ss_ptr after empty return", 32'(ss_ptr), 32'(SS_BASE));

    // R10: collision at equality, accepted one byte above.
    do_call('h0200, 'h0500, 'h0105);
    chk("R10", "dom after refused call", 32'(cur_dom), 32'd0);
    do_call('h0210, 'h0500, 'h0106);
    chk("R3", "callee of 0x210", 32'(cur_dom), 32'd1);
    do_call('h0220, 'h0600, 'h0104);
    do_ret('h0106);
    chk("R9", "dom after edge return", 32'(cur_dom), 32'd0);

    // Call at the exact table base.
    do_call('h0200, 'h0700, 'h0C00);
    chk("R2", "base address accepted", 32'(ss_ptr), 32'(SS_BASE + 5));
    do_ret('h0C00);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule